// File: doc/BRIEF.md
# Parallel De-interleave Address Generator

This block produces the read addresses needed to de-interleave one user's frame of soft chips when the frame is spread over several memory banks that parallel processors read at the same time. The frame is a matrix of `LANES` rows by `COLS` columns. Each row is held in its own bank, and each bank is `COLS` entries deep. In every active cycle the block handles one column and outputs one bank/offset pair per lane. The bank indices within a cycle are always a permutation of the lanes, so no two lanes ever read the same bank at once.

Each address is built in two stages. The first stage uses a seeded pseudo-random permutation that runs down the column and picks the bank. The second stage looks up a per-row cyclically shifted copy of a base row permutation, which picks the offset inside that bank. The cyclic shift starts at floor(COLS/K)·k for user k out of K users, and each row adds one more step. A receiver that starts the block with the same seed as the transmitter rebuilds the same pattern.

The base row permutation is loaded through a small write port while the block is idle. A start pulse then latches the user index, the user count and the seed. A short serial divide works out the user offset, after which the block streams `COLS` columns and gives a one-cycle done pulse at the end.

Top module: `pil_addr_gen`

## Requirements
- R1: After reset, `valid` and `done` are 0, `col_idx` is 0, and the base table holds the identity (entry i = i).
- R2: A start accepted at a clock edge raises `valid` after the (CW+2)-th following edge, where CW = log2(COLS). `valid` then stays high for exactly COLS cycles, and `col_idx` steps through 0, 1, …, COLS−1 during those cycles.
- R3: `done` is high for exactly one cycle, which is the cycle right after the last valid column. In that cycle `valid` is 0.
- R4: A start pulse that arrives while the block is not idle (dividing, streaming or signalling done) is ignored. The current frame goes on unchanged.
- R5: Column state s: a 16-bit register loaded with the seed at start (a seed of 0 is replaced by 1). It advances once per column by s ← (s>>1) XOR (s[0] ? 0xB400 : 0). Column w uses s after w advances. Lane m's bank, in field m of `bank_idx` (bits m·RW upward, RW = log2(LANES)), is ((s mod LANES) XOR m + (s / LANES) mod LANES) mod LANES.
- R6: In every valid cycle the LANES bank indices are pairwise distinct.
- R7: With K' = max(K,1) and shift = (floor(COLS/K')·k) mod COLS, lane m's offset, in field m of `offset_idx` (bits m·CW upward), is base[(w + shift + bank_m) mod COLS].
- R8: If the base table holds a permutation, every (bank, offset) pair appears exactly once over a whole frame.
- R9: A table write (`tbl_we`, `tbl_addr`, `tbl_data`) takes effect only while the block is idle. A write attempted during a frame or during the done cycle changes nothing.
- R10: User-count corners: K = 0 behaves like K = 1, and K > COLS gives a zero shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a frame (taken only when idle) |
| user_idx | input | KW | User index k |
| user_seed | input | 16 | Per-user column seed |
| user_count | input | KW | Number of users K |
| tbl_we | input | 1 | Base table write enable |
| tbl_addr | input | CW | Base table write address |
| tbl_data | input | CW | Base table write data |
| valid | output | 1 | Column addresses valid |
| done | output | 1 | One-cycle end-of-frame pulse |
| col_idx | output | CW | Current column w |
| bank_idx | output | LANES·RW | Bank index per lane |
| offset_idx | output | LANES·CW | In-bank offset per lane |

## Verification
After the edge that samples start, the bench counts edges. It expects `valid` low through the CW+1 edges of the divide and the multiply, then high after edge CW+2 for COLS consecutive cycles, with `done` on the following cycle only. Inputs are driven on falling edges and outputs are sampled on falling edges, so every check reads the state settled after a known count of rising edges. Expected banks and offsets come from the bench's own copy of the LFSR and the shift rule, and it walks these column by column alongside the design. Start and table-write pokes are placed in the divide, stream and done cycles, and their results are read on the following columns and in the next frame.

// File: rtl/pil_pkg.sv
package pil_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_MUL,
    ST_RUN,
    ST_FIN
  } pil_state_e;

  // Galois LFSR advance, taps 0xB400
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  // Column permutation: xor with lane, then rotate; bijective on 0..lanes-1
  function automatic int unsigned col_bank(input logic [15:0] s,
                                           input int unsigned lane,
                                           input int unsigned lanes);
    int unsigned lo;
    int unsigned hi;
    lo = int'(s) % lanes;
    hi = (int'(s) / lanes) % lanes;
    return ((lo ^ lane) + hi) % lanes;
  endfunction

  // Cyclic row shift into the base table
  function automatic int unsigned rot_idx(input int unsigned w,
                                          input int unsigned sh,
                                          input int unsigned b,
                                          input int unsigned cols);
    return (w + sh + b) % cols;
  endfunction

  function automatic int unsigned mul_mod(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned m);
    return (a * b) % m;
  endfunction

endpackage

// File: rtl/pil_div.sv
module pil_div #(
  parameter int NW = 5,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          last,
  output logic [NW-1:0] quot
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DW-1:0]   rem_q;
  logic [DW-1:0]   dsr_q;
  logic [NW-1:0]   dvd_q;
  logic [NW-1:0]   q_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q;

  logic [DW:0]     rsh;
  logic            ge;
  logic [DW-1:0]   rnext;

  always_comb begin
    rsh   = {rem_q, dvd_q[NW-1]};
    ge    = rsh >= {1'b0, dsr_q};
    rnext = ge ? DW'(rsh - {1'b0, dsr_q}) : rsh[DW-1:0];
  end

  assign last = busy_q && (cnt_q == CNTW'(NW - 1));
  assign quot = q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dsr_q  <= '0;
      dvd_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go) begin
      rem_q  <= '0;
      dsr_q  <= divisor;
      dvd_q  <= dividend;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= rnext;
      dvd_q <= {dvd_q[NW-2:0], 1'b0};
      q_q   <= {q_q[NW-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assert_rem_below_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !go |=> rem_q < dsr_q);

endmodule

// File: rtl/pil_col_perm.sv
module pil_col_perm #(
  parameter int LANES = 8,
  parameter int RW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [15:0]       seed,
  input  logic              step,
  output logic [LANES*RW-1:0] bank
);
  import pil_pkg::*;

  logic [15:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      s_q <= 16'h0001;
    else if (load)
      s_q <= (seed == 16'h0000) ? 16'h0001 : seed;
    else if (step)
      s_q <= lfsr_next(s_q);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bank[g*RW +: RW] = RW'(col_bank(s_q, g, LANES));
  end

  assert_state_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load || step |=> s_q != 16'h0000);

endmodule

// File: rtl/pil_row_table.sv
module pil_row_table #(
  parameter int COLS  = 16,
  parameter int LANES = 8,
  parameter int CW    = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CW-1:0]        waddr,
  input  logic [CW-1:0]        wdata,
  input  logic [LANES*CW-1:0]  raddr,
  output logic [LANES*CW-1:0]  rdata
);
  logic [CW-1:0] mem [COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COLS; i++) mem[i] <= CW'(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rdata[g*CW +: CW] = mem[raddr[g*CW +: CW]];
  end

endmodule

// File: rtl/pil_addr_gen.sv
module pil_addr_gen #(
  parameter int LANES     = 8,
  parameter int COLS      = 16,
  parameter int USERS_MAX = 32,
  parameter int RW        = $clog2(LANES),
  parameter int CW        = $clog2(COLS),
  parameter int KW        = $clog2(USERS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [KW-1:0]       user_idx,
  input  logic [15:0]         user_seed,
  input  logic [KW-1:0]       user_count,
  input  logic                tbl_we,
  input  logic [CW-1:0]       tbl_addr,
  input  logic [CW-1:0]       tbl_data,
  output logic                valid,
  output logic                done,
  output logic [CW-1:0]       col_idx,
  output logic [LANES*RW-1:0] bank_idx,
  output logic [LANES*CW-1:0] offset_idx
);
  import pil_pkg::*;

  localparam int NW = CW + 1;

  pil_state_e      state;
  logic [KW-1:0]   k_q;
  logic [KW-1:0]   kc_q;
  logic [CW-1:0]   shift_q;
  logic [CW-1:0]   w_q;

  // named internal events
  logic            accept;
  logic            col_step;
  logic            last_col;
  logic            tbl_wr_ok;
  logic [KW-1:0]   kc_in;
  logic            div_last;
  logic [NW-1:0]   div_q;
  logic [LANES*CW-1:0] rd_addr;
  logic [LANES-1:0]    bank_mask;

  assign accept    = start && (state == ST_IDLE);
  assign col_step  = (state == ST_RUN);
  assign last_col  = col_step && (w_q == CW'(COLS - 1));
  assign tbl_wr_ok = tbl_we && (state == ST_IDLE);
  assign kc_in     = (user_count == '0) ? KW'(1) : user_count;

  pil_div #(.NW(NW), .DW(KW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (accept),
    .dividend (NW'(COLS)),
    .divisor  (kc_in),
    .last     (div_last),
    .quot     (div_q)
  );

  pil_col_perm #(.LANES(LANES), .RW(RW)) u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .seed  (user_seed),
    .step  (col_step),
    .bank  (bank_idx)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_addr
    assign rd_addr[g*CW +: CW] =
      CW'(rot_idx(w_q, shift_q, bank_idx[g*RW +: RW], COLS));
  end

  pil_row_table #(.COLS(COLS), .LANES(LANES), .CW(CW)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_wr_ok),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (rd_addr),
    .rdata (offset_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      k_q     <= '0;
      kc_q    <= KW'(1);
      shift_q <= '0;
      w_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          k_q   <= user_idx;
          kc_q  <= kc_in;
          state <= ST_DIV;
        end
        ST_DIV: if (div_last) state <= ST_MUL;
        ST_MUL: begin
          shift_q <= CW'(mul_mod(div_q, k_q, COLS));
          w_q     <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          if (last_col) state <= ST_FIN;
          else          w_q   <= w_q + 1'b1;
        end
        ST_FIN: begin
          w_q   <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign valid   = col_step;
  assign done    = (state == ST_FIN);
  assign col_idx = w_q;

  always_comb begin
    bank_mask = '0;
    for (int m = 0; m < LANES; m++) bank_mask[bank_idx[m*RW +: RW]] = 1'b1;
  end

  assert_banks_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones(bank_mask) == LANES);

  assert_col_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(valid) |-> col_idx == CW'($past(col_idx) + 1'b1));

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(valid) && $past(col_idx) == CW'(COLS - 1) && !valid);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) && start |=> valid || done);

  assert_div_quot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUL) |-> (int'(div_q) * int'(kc_q) <= COLS) &&
                          ((int'(div_q) + 1) * int'(kc_q) > COLS));

endmodule

// File: tb/pil_addr_gen_tb.sv
module pil_addr_gen_tb;
  localparam int LANES     = 8;
  localparam int COLS      = 16;
  localparam int USERS_MAX = 32;
  localparam int RW        = $clog2(LANES);
  localparam int CW        = $clog2(COLS);
  localparam int KW        = $clog2(USERS_MAX + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [KW-1:0]       user_idx = '0;
  logic [15:0]         user_seed = '0;
  logic [KW-1:0]       user_count = '0;
  logic                tbl_we = 1'b0;
  logic [CW-1:0]       tbl_addr = '0;
  logic [CW-1:0]       tbl_data = '0;
  logic                valid;
  logic                done;
  logic [CW-1:0]       col_idx;
  logic [LANES*RW-1:0] bank_idx;
  logic [LANES*CW-1:0] offset_idx;

  int tests = 0;
  int fails = 0;
  int base [COLS];

  always #10 clk = ~clk;

  pil_addr_gen #(.LANES(LANES), .COLS(COLS), .USERS_MAX(USERS_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .user_idx(user_idx),
    .user_seed(user_seed), .user_count(user_count), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .valid(valid), .done(done),
    .col_idx(col_idx), .bank_idx(bank_idx), .offset_idx(offset_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lfsr_adv(input int s);
    int n;
    n = s >> 1;
    if ((s & 1) != 0) n = n ^ 32'hB400;
    return n & 32'hFFFF;
  endfunction

  function automatic int exp_bank(input int s, input int m);
    return (((s % LANES) ^ m) + ((s / LANES) % LANES)) % LANES;
  endfunction

  task automatic load_perm();
    for (int i = 0; i < COLS; i++) base[i] = i;
    for (int i = COLS - 1; i > 0; i--) begin
      int j;
      int t;
      j = int'($urandom % (i + 1));
      t = base[i]; base[i] = base[j]; base[j] = t;
    end
    for (int i = 0; i < COLS; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = CW'(i); tbl_data = CW'(base[i]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_frame(input int k, input int kn, input int seed, input bit poke);
    int ke;
    int sh;
    int s;
    int bad;
    bit seen [LANES][COLS];
    for (int a = 0; a < LANES; a++)
      for (int b = 0; b < COLS; b++) seen[a][b] = 1'b0;
    ke = (kn == 0) ? 1 : kn;          // R10
    sh = ((COLS / ke) * k) % COLS;
    s  = (seed == 0) ? 1 : seed;
    @(negedge clk);
    user_idx = KW'(k); user_count = KW'(kn); user_seed = 16'(seed); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = 0;
    for (int j = 0; j < CW + 2; j++) begin
      if (valid) bad++;
      if (poke && j == 1) begin
        start = 1'b1; user_seed = 16'h1357; user_idx = KW'(k + 1); // R4 poke during divide
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(bad == 0, "R2 latency low", bad, 0);
    for (int w = 0; w < COLS; w++) begin
      logic [LANES-1:0] mask;
      mask = '0;
      check(valid == 1'b1 && int'(col_idx) == w, "R2/R4 column", int'(col_idx), w);
      for (int m = 0; m < LANES; m++) begin
        int eb;
        int ab;
        int ao;
        int eo;
        eb = exp_bank(s, m);
        ab = int'(bank_idx[m*RW +: RW]);
        ao = int'(offset_idx[m*CW +: CW]);
        eo = base[(w + sh + eb) % COLS];
        check(ab == eb, "R5 bank", ab, eb);
        check(ao == eo, "R7 offset", ao, eo);
        mask[ab] = 1'b1;
        seen[ab][ao] = 1'b1;
      end
      check($countones(mask) == LANES, "R6 distinct banks", $countones(mask), LANES);
      if (poke && w == 3) begin
        start = 1'b1; user_seed = 16'hBEEF;              // R4 poke during stream
        tbl_we = 1'b1; tbl_addr = CW'(w); tbl_data = CW'(base[w] + 1); // R9 write while busy
      end
      s = lfsr_adv(s);
      @(negedge clk);
      start = 1'b0; tbl_we = 1'b0;
    end
    check(done == 1'b1 && valid == 1'b0, "R3 done pulse", int'(done), 1);
    if (poke) begin
      start = 1'b1;                                      // R4 poke during done cycle
      tbl_we = 1'b1; tbl_addr = '0; tbl_data = CW'(base[0] + 3); // R9 write in done cycle
    end
    @(negedge clk);
    start = 1'b0; tbl_we = 1'b0;
    check(done == 1'b0 && valid == 1'b0, "R3 single done", int'(done), 0);
    bad = 0;
    for (int a = 0; a < LANES; a++)
      for (int b = 0; b < COLS; b++) if (!seen[a][b]) bad++;
    check(bad == 0, "R8 frame coverage", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < COLS; i++) base[i] = i;   // R1 identity table after reset
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid reset", int'(valid), 0);
    check(done == 1'b0, "R1 done reset", int'(done), 0);
    check(col_idx == '0, "R1 col reset", int'(col_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 1, 1, 1'b0);        // R1 identity base in use
    run_frame(5, 0, 0, 1'b1);        // R10 K=0, seed 0; R4/R9 pokes
    run_frame(7, 20, 16'hACE1, 1'b0);// R10 K above COLS
    run_frame(2, 3, 16'h00FF, 1'b1);
    for (int f = 0; f < 6; f++) begin
      int kn;
      int k;
      load_perm();                   // R9 write while idle
      kn = 1 + int'($urandom % USERS_MAX);
      k  = int'($urandom % kn);
      run_frame(k, kn, int'($urandom & 32'hFFFF), f[0]);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule